// File: doc/BRIEF.md
# Four-Plane Graphics Memory Write Path

This block is the memory-write path of a 16-colour display controller whose frame store is split into four 8-bit bit-planes sharing one address. A processor programs a small bank of control registers through a two-step port: it first writes a register number to the index port, then writes the value to the data port. Either port can be read back.

Every memory access touches all four planes at one address. A read fills a 32-bit latch with one byte from each plane and returns a byte chosen by the read mode. A write builds each plane's new byte from one of three sources: the processor byte after a right rotation, a per-plane set/reset colour, or the latch. The byte is then combined with the latch by a logic operation and merged under a bit mask. A 4-bit plane-enable input decides which planes are stored. Because the latch is kept between accesses, a read followed by a write can move four planes of data with one byte of bus traffic, or can change a few pixels while keeping the rest.

Top module: `planar_write_path`

## Requirements
- R1: After reset the index register is 0, the bit-mask register (index 8) is 8'hFF, all other registers read 0 and memRvalid is 0.
- R2: With regSel=0 a write stores the index and a read returns it. With regSel=1 a write goes to the indexed register and a read returns it. Indices 0 set/reset value [3:0], 1 set/reset enable [3:0], 2 compare colour [3:0], 3 rotate/operation, 4 read-plane select [1:0], 5 mode, 7 compare mask [3:0] and 8 bit mask [7:0] are implemented. Writes to any other index are ignored and read as 0.
- R3: A memory read loads the latch with all four planes at memAddr. memRdata and memRvalid=1 appear one cycle later.
- R4: In read mode 0 (mode register bit 3 = 0), memRdata is the byte of the plane selected by index 4 bits [1:0].
- R5: In write mode 0 (mode register bits [1:0] = 0, and also 3), the processor byte is rotated right by index 3 bits [2:0] before the logic operation.
- R6: In write modes 0 and 3, a plane whose set/reset enable bit is 1 uses its set/reset value bit copied to all eight bits in place of the rotated byte.
- R7: Index 3 bits [4:3] select the operation with that plane's latch byte: 0 pass, 1 AND, 2 OR, 3 XOR.
- R8: Where a bit-mask bit is 1 the stored bit comes from the operation result. Where it is 0 the stored bit comes from the latch.
- R9: In write mode 1 each enabled plane stores its latch byte unchanged, whatever the processor data, operation or mask.
- R10: In write mode 2, processor data bit p is copied to all eight bits of plane p's source byte. That byte then goes through the operation and the bit mask.
- R11: Only planes whose planeEn bit is 1 are written. The other planes keep their previous contents.
- R12: In read mode 1, memRdata bit b is 1 when, for every plane p with compare-mask bit p set, bit b of plane p equals compare-colour bit p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0 selects the index port, 1 the data port |
| regWr | input | 1 | Register port write strobe |
| regWdata | input | 8 | Register port write data |
| regRdata | output | 8 | Register port read data (combinational) |
| memReq | input | 1 | Memory access request, one cycle per access |
| memWe | input | 1 | 1 write, 0 read |
| memAddr | input | ADDR_W | Byte address in every plane |
| memWdata | input | 8 | Processor write byte |
| planeEn | input | 4 | Per-plane write enable |
| memRdata | output | 8 | Read result, registered |
| memRvalid | output | 1 | High the cycle after a read |

## Verification
The hardest state to reach is a write whose outcome depends on a latch holding a different value in each plane. The bench gets there by first writing distinct bytes per plane with set/reset enabled for some planes only. It then reads that address to fill the latch, and only then issues the write under test. Every plane check reads the memory back, and that read reloads the latch, so each scenario reloads the latch explicitly before each dependent write.

// File: rtl/planar_pkg.sv
package planar_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ALU_PASS = 2'd0, ALU_AND = 2'd1, ALU_OR = 2'd2, ALU_XOR = 2'd3} aluOp_t;
  typedef enum logic [1:0] {WM_DIRECT = 2'd0, WM_LATCH = 2'd1, WM_EXPAND = 2'd2, WM_ALT = 2'd3} wrMode_t;

  typedef struct packed {
    logic rdStb;
    logic wrStb;
  } memStb_t;

  typedef struct packed {
    logic [PLANES-1:0] srVal;
    logic [PLANES-1:0] srEn;
    logic [PLANES-1:0] cmpVal;
    logic [2:0]        rotCnt;
    aluOp_t            aluOp;
    logic [1:0]        readSel;
    wrMode_t           wrMode;
    logic              rdMode;
    logic [PLANES-1:0] cmpMask;
    logic [BYTE_W-1:0] bitMask;
  } gfxCfg_t;
endpackage

// File: rtl/planar_ctrl.sv
module planar_ctrl
  import planar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              memReq,
  input  logic              memWe,
  output gfxCfg_t           cfg,
  output memStb_t           stb
);
  localparam logic [7:0] IDX_SRVAL  = 8'd0;
  localparam logic [7:0] IDX_SREN   = 8'd1;
  localparam logic [7:0] IDX_CMP    = 8'd2;
  localparam logic [7:0] IDX_ROT    = 8'd3;
  localparam logic [7:0] IDX_RDSEL  = 8'd4;
  localparam logic [7:0] IDX_MODE   = 8'd5;
  localparam logic [7:0] IDX_CMASK  = 8'd7;
  localparam logic [7:0] IDX_BMASK  = 8'd8;

  logic [BYTE_W-1:0] idxQ;
  gfxCfg_t cfgQ;
  logic dataWr;

  assign dataWr = regWr && regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      cfgQ <= '{srVal: '0, srEn: '0, cmpVal: '0, rotCnt: '0, aluOp: ALU_PASS,
                readSel: '0, wrMode: WM_DIRECT, rdMode: 1'b0, cmpMask: '0,
                bitMask: {BYTE_W{1'b1}}};
    end else begin
      if (regWr && !regSel) idxQ <= regWdata;
      if (dataWr) begin
        case (idxQ)
          IDX_SRVAL: cfgQ.srVal   <= regWdata[PLANES-1:0];
          IDX_SREN:  cfgQ.srEn    <= regWdata[PLANES-1:0];
          IDX_CMP:   cfgQ.cmpVal  <= regWdata[PLANES-1:0];
          IDX_ROT: begin
            cfgQ.rotCnt <= regWdata[2:0];
            cfgQ.aluOp  <= aluOp_t'(regWdata[4:3]);
          end
          IDX_RDSEL: cfgQ.readSel <= regWdata[1:0];
          IDX_MODE: begin
            cfgQ.wrMode <= wrMode_t'(regWdata[1:0]);
            cfgQ.rdMode <= regWdata[3];
          end
          IDX_CMASK: cfgQ.cmpMask <= regWdata[PLANES-1:0];
          IDX_BMASK: cfgQ.bitMask <= regWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (!regSel) begin
      regRdata = idxQ;
    end else begin
      case (idxQ)
        IDX_SRVAL: regRdata = {4'b0, cfgQ.srVal};
        IDX_SREN:  regRdata = {4'b0, cfgQ.srEn};
        IDX_CMP:   regRdata = {4'b0, cfgQ.cmpVal};
        IDX_ROT:   regRdata = {3'b0, cfgQ.aluOp, cfgQ.rotCnt};
        IDX_RDSEL: regRdata = {6'b0, cfgQ.readSel};
        IDX_MODE:  regRdata = {4'b0, cfgQ.rdMode, 1'b0, cfgQ.wrMode};
        IDX_CMASK: regRdata = {4'b0, cfgQ.cmpMask};
        IDX_BMASK: regRdata = cfgQ.bitMask;
        default:   regRdata = '0;
      endcase
    end
  end

  assign cfg = cfgQ;
  assign stb.rdStb = memReq && !memWe;
  assign stb.wrStb = memReq && memWe;

  // R2
  index_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSel) |=> (idxQ == $past(regWdata)));

  // R8
  mask_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && idxQ == IDX_BMASK) |=> (cfg.bitMask == $past(regWdata)));
endmodule

// File: rtl/planar_datapath.sv
module planar_datapath
  import planar_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfxCfg_t           cfg,
  input  memStb_t           stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memWdata,
  input  logic [PLANES-1:0] planeEn,
  output logic [BYTE_W-1:0] memRdata,
  output logic              memRvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PLANES-1:0][BYTE_W-1:0] rdBytes;
  logic [PLANES-1:0][BYTE_W-1:0] latchQ;
  logic [PLANES-1:0][BYTE_W-1:0] newByte;
  logic [BYTE_W-1:0] rotByte;
  logic [BYTE_W-1:0] cmpHit;
  logic [BYTE_W-1:0] readByte;

  // right rotate of the processor byte
  logic [2*BYTE_W-1:0] rotPair;
  assign rotPair = {memWdata, memWdata} >> cfg.rotCnt;
  assign rotByte = rotPair[BYTE_W-1:0];

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] store [DEPTH];
    logic [BYTE_W-1:0] srcByte;
    logic [BYTE_W-1:0] aluByte;

    assign rdBytes[p] = store[memAddr];

    always_comb begin
      case (cfg.wrMode)
        WM_EXPAND: srcByte = {BYTE_W{memWdata[p]}};
        default:   srcByte = cfg.srEn[p] ? {BYTE_W{cfg.srVal[p]}} : rotByte;
      endcase
      case (cfg.aluOp)
        ALU_AND: aluByte = srcByte & latchQ[p];
        ALU_OR:  aluByte = srcByte | latchQ[p];
        ALU_XOR: aluByte = srcByte ^ latchQ[p];
        default: aluByte = srcByte;
      endcase
      if (cfg.wrMode == WM_LATCH) newByte[p] = latchQ[p];
      else newByte[p] = (aluByte & cfg.bitMask) | (latchQ[p] & ~cfg.bitMask);
    end

    always_ff @(posedge clk) begin
      if (stb.wrStb && planeEn[p]) store[memAddr] <= newByte[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN) latchQ[p] <= '0;
      else if (stb.rdStb) latchQ[p] <= rdBytes[p];
    end

    // R11
    plane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrStb && !planeEn[p]) |=> (store[$past(memAddr)] == $past(rdBytes[p])));

    // R9
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrStb && planeEn[p] && cfg.wrMode == WM_LATCH) |=> (store[$past(memAddr)] == $past(latchQ[p])));

    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrStb && planeEn[p] && cfg.bitMask == '0) |=> (store[$past(memAddr)] == $past(latchQ[p])));
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_cmp
    logic [PLANES-1:0] planeMatch;
    for (genvar p = 0; p < PLANES; p++) begin : g_pm
      assign planeMatch[p] = ~cfg.cmpMask[p] | (rdBytes[p][b] ~^ cfg.cmpVal[p]);
    end
    assign cmpHit[b] = &planeMatch;
  end

  assign readByte = cfg.rdMode ? cmpHit : rdBytes[cfg.readSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRdata  <= '0;
      memRvalid <= 1'b0;
    end else begin
      memRvalid <= stb.rdStb;
      if (stb.rdStb) memRdata <= readByte;
    end
  end

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStb |=> memRvalid);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(latchQ));
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import planar_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWdata,
  input  logic [3:0]        planeEn,
  output logic [7:0]        memRdata,
  output logic              memRvalid
);
  gfxCfg_t cfg;
  memStb_t stb;

  planar_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .cfg(cfg), .stb(stb)
  );

  planar_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .memAddr(memAddr),
    .memWdata(memWdata), .planeEn(planeEn), .memRdata(memRdata),
    .memRvalid(memRvalid)
  );
endmodule

// File: tb/planar_write_path_tb.sv
module planar_write_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic memReq = 1'b0;
  logic memWe = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [7:0] memWdata = '0;
  logic [3:0] planeEn = 4'hF;
  logic [7:0] memRdata;
  logic memRvalid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_write_path #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .planeEn(planeEn), .memRdata(memRdata), .memRvalid(memRvalid)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); regWr = 1'b1; regSel = 1'b0; regWdata = idx;
    @(negedge clk); regSel = 1'b1; regWdata = val;
    @(negedge clk); regWr = 1'b0; regSel = 1'b0;
  endtask

  task automatic getReg(input logic [7:0] idx, output logic [7:0] val);
    @(negedge clk); regWr = 1'b1; regSel = 1'b0; regWdata = idx;
    @(negedge clk); regWr = 1'b0; regSel = 1'b1;
    #1 val = regRdata;
    regSel = 1'b0;
  endtask

  task automatic memRead(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); memReq = 1'b1; memWe = 1'b0; memAddr = a;
    @(negedge clk); memReq = 1'b0; d = memRdata; v = memRvalid;
  endtask

  task automatic loadLatch(input logic [ADDR_W-1:0] a);
    logic [7:0] d; logic v;
    memRead(a, d, v);
  endtask

  task automatic memWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [3:0] pe);
    @(negedge clk); memReq = 1'b1; memWe = 1'b1; memAddr = a; memWdata = d; planeEn = pe;
    @(negedge clk); memReq = 1'b0; memWe = 1'b0; planeEn = 4'hF;
  endtask

  task automatic checkPlane(input string req, input logic [ADDR_W-1:0] a, input int p, input logic [7:0] exp);
    logic [7:0] d; logic v;
    setReg(8'd4, 8'(p));
    memRead(a, d, v);
    check(req, d, exp);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 memRvalid", {7'b0, memRvalid}, 8'h00);
    #1 check("R1 index", regRdata, 8'h00);
    getReg(8'd8, d); check("R1 bitmask", d, 8'hFF);
    getReg(8'd3, d); check("R1 rotate", d, 8'h00);
    getReg(8'd7, d); check("R1 cmpmask", d, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    setReg(8'd3, 8'h1D);
    getReg(8'd3, d); check("R2 rotate readback", d, 8'h1D);
    setReg(8'd3, 8'h00);
    setReg(8'd6, 8'h77);
    getReg(8'd6, d); check("R2 unknown index", d, 8'h00);
    #1 regSel = 1'b0; #1 check("R2 index readback", regRdata, 8'h06);
    getReg(8'd3, d); check("R2 neighbour untouched", d, 8'h00);
  endtask

  task automatic testPlain();
    logic [7:0] d; logic v;
    memWrite(6'd1, 8'hA5, 4'hF);
    for (int p = 0; p < 4; p++) checkPlane("R4 plain write", 6'd1, p, 8'hA5);
    memRead(6'd1, d, v);
    check("R3 rvalid", {7'b0, v}, 8'h01);
  endtask

  task automatic testRotate();
    setReg(8'd3, 8'h03);
    memWrite(6'd2, 8'h01, 4'hF);
    setReg(8'd3, 8'h00);
    checkPlane("R5 rotate", 6'd2, 0, 8'h20);
  endtask

  task automatic testSetReset();
    setReg(8'd0, 8'h05);
    setReg(8'd1, 8'h03);
    memWrite(6'd3, 8'h3C, 4'hF);
    setReg(8'd1, 8'h00);
    checkPlane("R6 sr plane0", 6'd3, 0, 8'hFF);
    checkPlane("R6 sr plane1", 6'd3, 1, 8'h00);
    checkPlane("R6 cpu plane2", 6'd3, 2, 8'h3C);
    checkPlane("R6 cpu plane3", 6'd3, 3, 8'h3C);
  endtask

  task automatic testAlu();
    loadLatch(6'd1); setReg(8'd3, 8'h18);
    memWrite(6'd4, 8'hFF, 4'hF);
    checkPlane("R7 xor", 6'd4, 0, 8'h5A);
    loadLatch(6'd1); setReg(8'd3, 8'h08);
    memWrite(6'd4, 8'h0F, 4'hF);
    checkPlane("R7 and", 6'd4, 1, 8'h05);
    loadLatch(6'd1); setReg(8'd3, 8'h10);
    memWrite(6'd4, 8'h0F, 4'hF);
    checkPlane("R7 or", 6'd4, 2, 8'hAF);
    setReg(8'd3, 8'h00);
  endtask

  task automatic testMask();
    loadLatch(6'd1);
    setReg(8'd8, 8'h0F);
    memWrite(6'd6, 8'h00, 4'hF);
    setReg(8'd8, 8'hFF);
    checkPlane("R8 bit mask", 6'd6, 3, 8'hA0);
  endtask

  task automatic testCopy();
    loadLatch(6'd3);
    setReg(8'd5, 8'h01);
    memWrite(6'd7, 8'h00, 4'hF);
    setReg(8'd5, 8'h00);
    checkPlane("R9 copy plane0", 6'd7, 0, 8'hFF);
    checkPlane("R9 copy plane1", 6'd7, 1, 8'h00);
    checkPlane("R9 copy plane2", 6'd7, 2, 8'h3C);
  endtask

  task automatic testExpand();
    setReg(8'd5, 8'h02);
    memWrite(6'd8, 8'h06, 4'hF);
    loadLatch(6'd1);
    setReg(8'd8, 8'hF0);
    memWrite(6'd9, 8'h01, 4'hF);
    setReg(8'd8, 8'hFF);
    setReg(8'd5, 8'h00);
    checkPlane("R10 expand plane0", 6'd8, 0, 8'h00);
    checkPlane("R10 expand plane1", 6'd8, 1, 8'hFF);
    checkPlane("R10 expand masked p0", 6'd9, 0, 8'hF5);
    checkPlane("R10 expand masked p1", 6'd9, 1, 8'h05);
  endtask

  task automatic testPlaneEn();
    memWrite(6'd1, 8'h00, 4'b0101);
    checkPlane("R11 enabled p0", 6'd1, 0, 8'h00);
    checkPlane("R11 disabled p1", 6'd1, 1, 8'hA5);
    checkPlane("R11 enabled p2", 6'd1, 2, 8'h00);
    checkPlane("R11 disabled p3", 6'd1, 3, 8'hA5);
  endtask

  task automatic testCompare();
    logic [7:0] d; logic v;
    setReg(8'd2, 8'h0D);
    setReg(8'd7, 8'h0F);
    setReg(8'd5, 8'h08);
    memRead(6'd3, d, v); check("R12 all planes", d, 8'h3C);
    setReg(8'd7, 8'h03);
    memRead(6'd3, d, v); check("R12 two planes", d, 8'hFF);
    setReg(8'd2, 8'h00);
    setReg(8'd7, 8'h01);
    memRead(6'd3, d, v); check("R12 mismatch", d, 8'h00);
    setReg(8'd5, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPlain();
    testRotate();
    testSetReset();
    testAlu();
    testMask();
    testCopy();
    testExpand();
    testPlaneEn();
    testCompare();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule